// File: doc/BRIEF.md
# Byte-Level Serial EEPROM Target

This block is the storage side of a two-wire serial EEPROM. A bit-level front end that is not part of this block decodes the bus. It hands over one-cycle events for a start condition (with the 7-bit device address), a received data byte, a byte to be sent, and a stop condition. The block replies one clock later with a response strobe, an acknowledge flag and, for reads, the data byte.

The target answers a group of consecutive device addresses. The low bits of the device address supply the memory-address bits above bit 7, so a 512-byte part answers two device addresses. The first byte written after a start sets the memory address. Later written bytes are stored one after another, and reads stream bytes out. The address steps up after every data byte and wraps to zero past the top of the array. A write-protect input blocks stores. While it is high, each data byte is refused with a not-acknowledge, but the address still moves on.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset `resp_valid`, `resp_ack` and `claimed` are 0 and `rd_data` is 8'h00.
- R2: A start event sets `claimed` when `bus_addr` equals `BUS_BASE` with the low log2(MEM_BYTES)-8 bits ignored. A start with any other address, or a stop event, clears `claimed`. While `claimed` is 0, a write is answered with `resp_ack`=0 and stores nothing, and a read is answered with `rd_data`=8'hFF and `resp_ack`=0.
- R3: A start loads the address register with (bus_addr << 8) masked by MEM_BYTES-1. A read that immediately follows a start returns the byte at that address.
- R4: The first byte written after a start is not stored. It sets the address to ((bus_addr << 8) | byte) masked by MEM_BYTES-1 and is answered with `resp_ack`=1.
- R5: When `wp`=0, each later written byte is stored at the current address, answered with `resp_ack`=1, and the address then increments.
- R6: A read returns the byte at the current address in `rd_data` with `resp_ack`=1, and the address then increments.
- R7: Incrementing from MEM_BYTES-1 wraps the address to 0, for both reads and writes.
- R8: When `wp`=1, a data byte is not stored and is answered with `resp_ack`=0, yet the address still increments.
- R9: Every write or read event is answered by `resp_valid`=1 exactly one clock later, and `resp_valid` is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start condition seen, device address valid on `bus_addr` |
| ev_stop | input | 1 | Stop condition seen |
| ev_wr | input | 1 | Byte received from the controller on `wr_data` |
| ev_rd | input | 1 | Controller requests a byte |
| bus_addr | input | 7 | Device address sampled with `ev_start` |
| wr_data | input | 8 | Received byte |
| wp | input | 1 | Write protect, 1 blocks stores |
| resp_valid | output | 1 | Response strobe, one cycle after a byte event |
| resp_ack | output | 1 | 1 acknowledge, 0 not-acknowledge |
| rd_data | output | 8 | Byte returned for a read |
| claimed | output | 1 | Target is addressed in the current transaction |

## Verification
A wrong address register shows up at the next read as a byte taken from another location, one clock after the read event. If the wrong value came from a bad write, it shows only when that location is read back. A stuck address phase shows on the first data write as a byte that was never stored or was stored at the wrong place, and a wrong gate on `wp` shows at once in `resp_ack`. A faulty wrap shows in the read that follows the top location. The bench fills the whole array first so that every read can be compared with a model.

// File: rtl/eeprom_tgt_pkg.sv
package eeprom_tgt_pkg;
  localparam int MAX_AW = 11;
  typedef logic [MAX_AW-1:0] waddr_t;

  // address loaded at a start: device bits above the byte field
  function automatic waddr_t page_base(logic [6:0] dev, waddr_t mask);
    return {dev[2:0], 8'h00} & mask;
  endfunction

  // address formed by the first written byte
  function automatic waddr_t join_addr(logic [6:0] dev, logic [7:0] lo, waddr_t mask);
    return {dev[2:0], lo} & mask;
  endfunction

  // post-access increment with wrap to zero
  function automatic waddr_t step_addr(waddr_t a, waddr_t mask);
    return (a >= mask) ? '0 : ((a + 1'b1) & mask);
  endfunction

  // device-address match with the page-select bits ignored
  function automatic logic dev_hit(logic [6:0] dev, logic [6:0] base, waddr_t mask);
    logic [6:0] dc;
    dc = {4'b0000, mask[10:8]};
    return (dev & ~dc) == (base & ~dc);
  endfunction
endpackage

// File: rtl/eeprom_claim.sv
module eeprom_claim
  import eeprom_tgt_pkg::*;
#(
  parameter logic [6:0] BUS_BASE = 7'h50,
  parameter waddr_t     MASK     = 11'h1FF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic [6:0] bus_addr,
  output logic       claimed,
  output logic       start_hit,
  output logic [6:0] dev_q
);
  assign start_hit = ev_start && dev_hit(bus_addr, BUS_BASE, MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claimed <= 1'b0;
      dev_q   <= '0;
    end else if (ev_start) begin
      claimed <= start_hit;
      dev_q   <= bus_addr;
    end else if (ev_stop) begin
      claimed <= 1'b0;
    end
  end
endmodule

// File: rtl/eeprom_addr_ctrl.sv
module eeprom_addr_ctrl
  import eeprom_tgt_pkg::*;
#(
  parameter int     AW   = 9,
  parameter waddr_t MASK = 11'h1FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_hit,
  input  logic [6:0]    start_dev,
  input  logic [6:0]    dev_q,
  input  logic          wr_go,
  input  logic          rd_go,
  input  logic [7:0]    wr_data,
  output logic [AW-1:0] cur_addr,
  output logic          data_phase,
  output logic          step
);
  logic set_ptr;

  assign set_ptr = wr_go && !data_phase;
  assign step    = (wr_go && data_phase) || rd_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr   <= '0;
      data_phase <= 1'b0;
    end else if (start_hit) begin
      cur_addr   <= AW'(page_base(start_dev, MASK));
      data_phase <= 1'b0;
    end else if (set_ptr) begin
      cur_addr   <= AW'(join_addr(dev_q, wr_data, MASK));
      data_phase <= 1'b1;
    end else if (step) begin
      cur_addr   <= AW'(step_addr(waddr_t'(cur_addr), MASK));
    end
  end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eeprom_tgt_pkg::*;
#(
  parameter int         MEM_BYTES = 512,
  parameter logic [6:0] BUS_BASE  = 7'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_wr,
  input  logic       ev_rd,
  input  logic [6:0] bus_addr,
  input  logic [7:0] wr_data,
  input  logic       wp,
  output logic       resp_valid,
  output logic       resp_ack,
  output logic [7:0] rd_data,
  output logic       claimed
);
  localparam int     AW   = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;
  localparam waddr_t MASK = waddr_t'(MEM_BYTES - 1);

  logic          start_hit;
  logic [6:0]    dev_q;
  logic          wr_go, rd_go, store;
  logic [AW-1:0] cur_addr;
  logic          data_phase, step;
  logic [7:0]    mem_q;

  assign wr_go = ev_wr && claimed && !ev_start && !ev_stop;
  assign rd_go = ev_rd && claimed && !ev_start && !ev_stop && !ev_wr;
  assign store = wr_go && data_phase && !wp;

  eeprom_claim #(.BUS_BASE(BUS_BASE), .MASK(MASK)) u_claim (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .bus_addr(bus_addr), .claimed(claimed), .start_hit(start_hit), .dev_q(dev_q)
  );

  eeprom_addr_ctrl #(.AW(AW), .MASK(MASK)) u_addr (
    .clk(clk), .rst_n(rst_n), .start_hit(start_hit), .start_dev(bus_addr),
    .dev_q(dev_q), .wr_go(wr_go), .rd_go(rd_go), .wr_data(wr_data),
    .cur_addr(cur_addr), .data_phase(data_phase), .step(step)
  );

  eeprom_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
    .clk(clk), .we(store), .addr(cur_addr), .wdata(wr_data), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
      rd_data    <= 8'h00;
    end else begin
      resp_valid <= (ev_wr || ev_rd) && !ev_start && !ev_stop;
      if (wr_go)      resp_ack <= !data_phase || !wp;
      else if (rd_go) resp_ack <= 1'b1;
      else            resp_ack <= 1'b0;
      if (rd_go)                      rd_data <= mem_q;
      else if (ev_rd && !ev_wr)       rd_data <= 8'hFF;
    end
  end
endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_start,
  input logic          ev_stop,
  input logic          ev_wr,
  input logic          ev_rd,
  input logic          wp,
  input logic          claimed,
  input logic          resp_valid,
  input logic          resp_ack,
  input logic [AW-1:0] cur_addr,
  input logic          data_phase,
  input logic          step
);
  logic quiet;
  assign quiet = !ev_start && !ev_stop;

  // R9
  resp_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(ev_wr || ev_rd));

  // R4
  ptr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && ev_wr && claimed && !data_phase) |=> (resp_ack && data_phase));

  // R8
  wp_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && ev_wr && claimed && data_phase && wp) |=> !resp_ack);

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && step && (&cur_addr)) |=> (cur_addr == '0));

  // R6
  addr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && step && !(&cur_addr)) |=> (cur_addr == $past(cur_addr) + 1'b1));

  // R2
  idle_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && (ev_wr || ev_rd) && !claimed) |=> !resp_ack);
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
  .ev_wr(ev_wr), .ev_rd(ev_rd), .wp(wp), .claimed(claimed),
  .resp_valid(resp_valid), .resp_ack(resp_ack), .cur_addr(cur_addr),
  .data_phase(data_phase), .step(step)
);

// File: tb/sim_i2c_eeprom_target.sv
module sim_i2c_eeprom_target;
  localparam int SZ = 512;
  localparam int BASE = 'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, ev_wr = 0, ev_rd = 0, wp = 0;
  logic [6:0] bus_addr = '0;
  logic [7:0] wr_data = '0;
  logic resp_valid, resp_ack, claimed;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;
  int m_mem [SZ];
  int m_ptr = 0;
  bit m_own = 0, m_dat = 0;
  int m_dev = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_eeprom_target #(.MEM_BYTES(SZ), .BUS_BASE(7'h50)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_wr(ev_wr), .ev_rd(ev_rd), .bus_addr(bus_addr), .wr_data(wr_data),
    .wp(wp), .resp_valid(resp_valid), .resp_ack(resp_ack),
    .rd_data(rd_data), .claimed(claimed)
  );

  function automatic bit owns(int dev);
    return (dev / (SZ / 256)) == (BASE / (SZ / 256));
  endfunction
  function automatic int page_start(int dev);
    return (dev * 256) % SZ;
  endfunction
  function automatic int bump(int a);
    return (a + 1 == SZ) ? 0 : a + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op_start(int dev);
    @(negedge clk); ev_start = 1; bus_addr = 7'(dev);
    @(negedge clk); ev_start = 0;
    m_own = owns(dev); m_dev = dev; m_dat = 0;
    if (m_own) m_ptr = page_start(dev);
    chk("R2 claim", claimed, m_own);
  endtask

  task automatic op_stop();
    @(negedge clk); ev_stop = 1;
    @(negedge clk); ev_stop = 0;
    m_own = 0;
    chk("R2 stop", claimed, 0);
  endtask

  task automatic op_write(int b, bit protect);
    int ack_e;
    @(negedge clk); ev_wr = 1; wr_data = 8'(b); wp = protect;
    @(negedge clk); ev_wr = 0; wp = 0;
    if (!m_own) ack_e = 0;
    else if (!m_dat) begin
      m_ptr = ((m_dev * 256) + b) % SZ; m_dat = 1; ack_e = 1;
    end else begin
      if (!protect) m_mem[m_ptr] = b;
      ack_e = protect ? 0 : 1;
      m_ptr = bump(m_ptr);
    end
    chk("R9 wr strobe", resp_valid, 1);
    chk(protect ? "R8 wp ack" : "R5/R4 ack", resp_ack, ack_e);
  endtask

  task automatic op_read(string req);
    @(negedge clk); ev_rd = 1;
    @(negedge clk); ev_rd = 0;
    chk("R9 rd strobe", resp_valid, 1);
    if (m_own) begin
      chk({req, " R6 data"}, rd_data, m_mem[m_ptr]);
      chk("R6 ack", resp_ack, 1);
      m_ptr = bump(m_ptr);
    end else begin
      chk("R2 idle data", rd_data, 'hFF);
      chk("R2 idle ack", resp_ack, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", resp_valid, 0); chk("R1 ack", resp_ack, 0);
    chk("R1 claimed", claimed, 0);  chk("R1 rd_data", rd_data, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 idle", resp_valid, 0);

    // fill whole array: ends wrapped at 0 (R7 write wrap)
    op_start(BASE); op_write(0, 0);
    for (int i = 0; i < SZ; i++) op_write((i * 37 + 5) & 255, 0);
    chk("R7 write wrap ptr", m_ptr, 0);
    op_read("R7 after write wrap");
    op_stop();

    // R3: read right after start on upper page
    op_start(BASE + 1); op_read("R3 page1 base");
    // R4: pointer set with page bits, read back
    op_start(BASE + 1); op_write('hFE, 0);
    op_start(BASE + 1);
    op_write('hFF, 0);
    op_read("R7 top"); op_read("R7 read wrap");

    // R8: write protect, address moves on
    op_start(BASE); op_write('h10, 0);
    op_write('hAA, 1); op_write('hBB, 0);
    op_start(BASE); op_write('h10, 0);
    op_read("R8 kept"); op_read("R8 advanced");

    // R2: unclaimed address, then stop
    op_start('h52); op_write('h33, 0); op_read("R2 foreign");
    op_start(BASE); op_stop(); op_write(1, 0); op_read("R2 after stop");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k == 0) op_start(($urandom_range(0, 5) == 0) ? 'h22 : BASE + $urandom_range(0, 2));
      else if (k == 1) op_stop();
      else if (k < 6) op_write($urandom_range(0, 255), $urandom_range(0, 4) == 0);
      else op_read("R6 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule